// File: doc/BRIEF.md
# Page Table Translation Unit with Region-Aware TLB

This block turns 32-bit device virtual addresses into 36-bit bus physical addresses. The translation table has one level that spans the whole 4 GB space: one 32-bit entry for each 4 KB page, indexed by VA[31:12]. The table sits in memory. In front of it is a fully associative translation cache with 8 slots. On a miss, the block issues one entry fetch over a single-beat read port. It then checks the entry and returns either the translated address or a fault.

Entries can mark their page as part of a 64 KB or a 1 MB region. In that case the cache keeps one slot that covers the whole region, so later accesses anywhere in the region need no further fetch.

Software reaches the block through a small register port. Through it software sets:
- the table location
- the enables
- a traffic limit on the page index
- a scratch frame that receives faulting traffic

The same port gives access to a sticky fault status, the last faulting address and a cache invalidation command with a busy indication.

Top module: `pt_mmu`

## Requirements
- R1: When control bit 0 (translate enable, register 0) is 0, an accepted request returns `rsp_pa` = {4'b0, VA} with no fault, one cycle after acceptance, and issues no table fetch.
- R2: On a miss, exactly one fetch is issued, as a one-cycle `mem_req` pulse. Its address is base*4096 + VA[31:12]*4, where base is register 1 bits [23:0]. The returned entry carries: bit 31 = 1 MB region, bit 30 = 64 KB region, bit 29 = writable, bit 28 = valid, bits [23:0] = frame.
- R3: A valid 4 KB entry yields PA = {frame, VA[11:0]}. It is cached, and a repeated access to the same page returns the same PA without a fetch.
- R4: An entry with bit 30 set (and bit 31 clear) is cached as a 64 KB region. Any VA with the same VA[31:16] hits and gets PA = {frame[23:4], VA[15:0]}.
- R5: An entry with bit 31 set is cached as a 1 MB region. Any VA with the same VA[31:20] hits and gets PA = {frame[23:8], VA[19:0]}.
- R6: The cache has 8 slots and fills them round robin. After 8 further distinct fills the oldest page misses, while the others still hit.
- R7: A fetched entry with bit 28 clear is never cached. If control bit 1 (invalid detection) is set, it faults and sets status bit 0 (register 5). If bit 1 is clear, it returns {frame, VA[11:0]} with no fault.
- R8: A write to a valid entry with bit 29 clear faults and sets status bit 1, whether the entry came from the cache or from a fetch. A read of the same page does not fault.
- R9: When translation is on and VA[31:12] exceeds the limit in register 3 bits [19:0] (reset value 0xFFFFF), the access faults, sets status bit 2, and issues no fetch.
- R10: For a fault, `rsp_fault` is 1 and `rsp_abort` follows the abort enable of its kind (control bits 2, 4, 6 for invalid, write, limit). `irq` is high while a status bit and its interrupt enable (control bits 3, 5, 7) are both set. Writing 1 to a status bit clears it.
- R11: When register 2 bit 31 is set, a faulting response carries PA = {register 2 bits [23:0], VA[11:0]} instead of the translated address.
- R12: Writing 1 to control bit 8 invalidates every cache slot. While this is in progress, register 5 bit 8 and register 0 bit 8 read 1 and `req_ready` is 0. After it ends, every page misses again.
- R13: Register 4 holds the virtual address of the most recent faulting access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response pulse |
| rsp_pa | output | 36 | Physical address of the response |
| rsp_fault | output | 1 | The access faulted |
| rsp_abort | output | 1 | The fault must abort the access |
| mem_req | output | 1 | Table entry fetch pulse |
| mem_addr | output | 36 | Byte address of the entry to fetch |
| mem_rvalid | input | 1 | Fetched entry present |
| mem_rdata | input | 32 | Fetched entry |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Fault interrupt |

## Verification
The hardest case to reach from the ports is round-robin eviction, because the replacement pointer cannot be seen. The bench first empties the cache with an invalidation. It then counts fetches across a fixed sequence of nine distinct pages followed by re-accesses. Because of that order, the expected hit/miss pattern is the same whatever the pointer's starting slot. A second hard case is showing that one fetched entry serves a whole 64 KB or 1 MB region. The bench checks this by touching a far corner of the region and confirming that the fetch count does not move.

// File: rtl/pt_mmu.sv
module pt_mmu #(
  parameter int NE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic        req_write,
  output logic        rsp_valid,
  output logic [35:0] rsp_pa,
  output logic        rsp_fault,
  output logic        rsp_abort,
  output logic        mem_req,
  output logic [35:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  localparam int IW = (NE > 1) ? $clog2(NE) : 1;

  typedef enum logic [1:0] {S_IDLE, S_WREQ, S_WAIT} st_t;
  st_t st;

  logic [7:0]  ctrl;
  logic [23:0] base, ill_pfn;
  logic        ill_en;
  logic [19:0] limit;
  logic [31:0] fault_va, va_q;
  logic [2:0]  fstat;
  logic        wr_q, clearing;
  logic [IW-1:0] clr_idx, rr;

  logic [NE-1:0] t_v, t_w;
  logic [19:0]   t_tag [NE];
  logic [1:0]    t_sz  [NE];
  logic [23:0]   t_pfn [NE];

  function automatic logic [35:0] mkpa(input logic [23:0] f, input logic [1:0] sz, input logic [31:0] va);
    case (sz)
      2'd2:    return {f[23:8], va[19:0]};
      2'd1:    return {f[23:4], va[15:0]};
      default: return {f, va[11:0]};
    endcase
  endfunction

  assign req_ready = (st == S_IDLE) && !clearing;
  assign mem_req   = (st == S_WREQ);
  assign mem_addr  = {base, 12'h000} + {14'd0, va_q[31:12], 2'b00};
  wire   acc       = req_valid && req_ready;

  logic        hit, hw;
  logic [1:0]  hsz;
  logic [23:0] hpfn;
  always_comb begin
    hit = 1'b0; hw = 1'b0; hsz = 2'd0; hpfn = '0;
    for (int i = 0; i < NE; i++) begin
      if (!hit && t_v[i] &&
          ((t_sz[i] == 2'd2) ? (t_tag[i][19:8] == req_va[31:20]) :
           (t_sz[i] == 2'd1) ? (t_tag[i][19:4] == req_va[31:16]) :
                               (t_tag[i] == req_va[31:12]))) begin
        hit = 1'b1; hw = t_w[i]; hsz = t_sz[i]; hpfn = t_pfn[i];
      end
    end
  end

  wire [1:0] psz = mem_rdata[31] ? 2'd2 : (mem_rdata[30] ? 2'd1 : 2'd0);

  logic        fire, fill, walk;
  logic [2:0]  fk;
  logic [35:0] tpa;
  always_comb begin
    fire = 1'b0; fill = 1'b0; walk = 1'b0; fk = 3'b000; tpa = '0;
    if (acc) begin
      if (!ctrl[0]) begin
        fire = 1'b1; tpa = {4'h0, req_va};
      end else if (req_va[31:12] > limit) begin
        fire = 1'b1; fk = 3'b100;
      end else if (hit) begin
        fire = 1'b1; tpa = mkpa(hpfn, hsz, req_va);
        if (req_write && !hw) fk = 3'b010;
      end else begin
        walk = 1'b1;
      end
    end else if (st == S_WAIT && mem_rvalid) begin
      fire = 1'b1; tpa = mkpa(mem_rdata[23:0], psz, va_q);
      if (!mem_rdata[28]) begin
        if (ctrl[1]) fk = 3'b001;
      end else begin
        fill = 1'b1;
        if (wr_q && !mem_rdata[29]) fk = 3'b010;
      end
    end
  end

  wire [31:0] fva     = acc ? req_va : va_q;
  wire        clr_go  = reg_wr && reg_addr == 3'd0 && reg_wdata[8];
  wire [2:0]  w1c     = (reg_wr && reg_addr == 3'd5) ? reg_wdata[2:0] : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ctrl <= '0; base <= '0; ill_pfn <= '0; ill_en <= 1'b0;
      limit <= '1; fault_va <= '0; va_q <= '0; wr_q <= 1'b0; fstat <= '0;
      clearing <= 1'b0; clr_idx <= '0; rr <= '0; t_v <= '0;
      rsp_valid <= 1'b0; rsp_pa <= '0; rsp_fault <= 1'b0; rsp_abort <= 1'b0;
    end else begin
      rsp_valid <= fire;
      if (fire) begin
        rsp_pa    <= (|fk && ill_en) ? {ill_pfn, fva[11:0]} : tpa;
        rsp_fault <= |fk;
        rsp_abort <= |(fk & {ctrl[6], ctrl[4], ctrl[2]});
      end
      if (|fk) fault_va <= fva;
      fstat <= (fstat & ~w1c) | fk;
      if (acc) begin va_q <= req_va; wr_q <= req_write; end
      case (st)
        S_IDLE:  if (walk) st <= S_WREQ;
        S_WREQ:  st <= S_WAIT;
        default: if (mem_rvalid) st <= S_IDLE;
      endcase
      if (fill) begin
        t_v[rr] <= 1'b1; t_w[rr] <= mem_rdata[29]; t_sz[rr] <= psz;
        t_tag[rr] <= va_q[31:12]; t_pfn[rr] <= mem_rdata[23:0];
        rr <= (rr == IW'(NE - 1)) ? '0 : rr + 1'b1;
      end
      if (clearing && st == S_IDLE) begin
        t_v[clr_idx] <= 1'b0;
        clr_idx <= clr_idx + 1'b1;
        if (clr_idx == IW'(NE - 1)) clearing <= 1'b0;
      end
      if (reg_wr) begin
        case (reg_addr)
          3'd0: ctrl <= reg_wdata[7:0];
          3'd1: base <= reg_wdata[23:0];
          3'd2: begin ill_pfn <= reg_wdata[23:0]; ill_en <= reg_wdata[31]; end
          3'd3: limit <= reg_wdata[19:0];
          default: ;
        endcase
      end
      if (clr_go) begin clearing <= 1'b1; clr_idx <= '0; end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {23'd0, clearing, ctrl};
      3'd1:    reg_rdata = {8'd0, base};
      3'd2:    reg_rdata = {ill_en, 7'd0, ill_pfn};
      3'd3:    reg_rdata = {12'd0, limit};
      3'd4:    reg_rdata = fault_va;
      3'd5:    reg_rdata = {23'd0, clearing, 5'd0, fstat};
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |(fstat & {ctrl[7], ctrl[5], ctrl[3]});

  a_r2_single_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r10_abort_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_abort |-> rsp_fault);
  a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> fstat != 3'b000);
  a_r6_fill_slot: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_WAIT && mem_rvalid && mem_rdata[28] |=> t_v[$past(rr)]);
  a_r12_all_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clearing) |-> t_v == '0);
  a_r1_no_walk_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !ctrl[0] |=> !mem_req);
endmodule

// File: tb/sim_pt_mmu.sv
module sim_pt_mmu;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [31:0] req_va = '0;
  logic        rsp_valid, rsp_fault, rsp_abort, mem_req, irq;
  logic [35:0] rsp_pa, mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  pt_mmu u0 (.*);

  int tests = 0, fails = 0, walks = 0;
  logic [35:0] last_addr = '0;
  int dly = 0;

  typedef struct { logic [35:0] pa; logic f; logic a; string tag; } exp_t;
  exp_t q[$];
  exp_t e;

  function automatic logic [31:0] pte_of(input logic [35:0] a);
    logic [35:0] idx = (a - 36'h0_0010_0000) >> 2;
    if (idx == 36'h5) return 32'h3000_0ABC;
    if (idx >= 36'h10 && idx <= 36'h1F) return 32'h7000_0200 | 32'(idx - 36'h10);
    if (idx >= 36'h100 && idx <= 36'h1FF) return 32'hB000_1000 | 32'(idx - 36'h100);
    if (idx == 36'h30) return 32'h1000_0333;
    if (idx >= 36'h200 && idx <= 36'h208) return 32'h3000_0500 | 32'(idx - 36'h200);
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      last_addr <= mem_addr; walks <= walks + 1; dly <= 2;
    end else if (dly != 0) begin
      dly <= dly - 1;
      if (dly == 1) begin mem_rvalid <= 1'b1; mem_rdata <= pte_of(last_addr); end
    end
  end

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rsp_valid) begin
      if (q.size() == 0) chk(1'b0, "unexpected response", 64'(rsp_pa), 0);
      else begin
        e = q.pop_front();
        chk(rsp_pa == e.pa, {e.tag, " pa"}, 64'(rsp_pa), 64'(e.pa));
        chk(rsp_fault == e.f && rsp_abort == e.a, {e.tag, " fault/abort"},
            {rsp_fault, rsp_abort}, {e.f, e.a});
      end
    end
  end

  task automatic xl(input logic [31:0] va, input bit wr, input logic [35:0] pa,
                    input bit f, input bit a, input string tag);
    exp_t x;
    x.pa = pa; x.f = f; x.a = a; x.tag = tag;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    q.push_back(x);
    req_va = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 0);
    summary();
  end

  initial begin
    logic [31:0] d;
    int w0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rreg(3'd0, d); chk(d == 0, "reset ctrl R12", d, 0);
    rreg(3'd5, d); chk(d == 0, "reset status R10", d, 0);
    rreg(3'd3, d); chk(d == 32'hFFFFF, "reset limit R9", d, 32'hFFFFF);
    chk(irq == 0 && req_ready == 1, "reset irq/ready R10", {irq, req_ready}, 2'b01);

    xl(32'h1234_5678, 0, 36'h0_1234_5678, 0, 0, "R1 passthrough");
    chk(walks == 0, "R1 no fetch", walks, 0);

    wreg(3'd1, 32'h0000_0100);
    wreg(3'd0, 32'h0000_00FF);
    xl(32'h0000_5123, 0, 36'h0_00AB_C123, 0, 0, "R3 miss");
    chk(walks == 1, "R2 one fetch", walks, 1);
    chk(last_addr == 36'h0_0010_0014, "R2 entry address", last_addr, 36'h0_0010_0014);
    xl(32'h0000_5123, 1, 36'h0_00AB_C123, 0, 0, "R3 hit");
    chk(walks == 1, "R3 hit no fetch", walks, 1);

    xl(32'h0001_3456, 0, 36'h0_0020_3456, 0, 0, "R4 big miss");
    xl(32'h0001_F004, 0, 36'h0_0020_F004, 0, 0, "R4 big region hit");
    chk(walks == 2, "R4 region cached", walks, 2);

    xl(32'h0015_5000, 1, 36'h0_0105_5000, 0, 0, "R5 super miss");
    xl(32'h001F_F008, 0, 36'h0_010F_F008, 0, 0, "R5 super region hit");
    chk(walks == 3, "R5 region cached", walks, 3);

    xl(32'h0002_0000, 0, 36'h0, 1, 1, "R7 invalid");
    rreg(3'd5, d); chk(d == 1, "R7 status bit", d, 1);
    chk(irq == 1, "R10 irq invalid", irq, 1);
    rreg(3'd4, d); chk(d == 32'h0002_0000, "R13 fault va", d, 32'h0002_0000);
    xl(32'h0002_0000, 0, 36'h0, 1, 1, "R7 invalid again");
    chk(walks == 5, "R7 not cached", walks, 5);
    wreg(3'd5, 32'h1);
    rreg(3'd5, d); chk(d == 0, "R10 w1c", d, 0);
    chk(irq == 0, "R10 irq cleared", irq, 0);

    wreg(3'd0, 32'h0000_00FD);
    xl(32'h0002_0000, 0, 36'h0, 0, 0, "R7 detect off");
    rreg(3'd5, d); chk(d == 0, "R7 detect off no status", d, 0);
    wreg(3'd0, 32'h0000_00FF);

    wreg(3'd2, 32'h8000_00EE);
    xl(32'h0003_0010, 1, 36'h0_000E_E010, 1, 1, "R8 R11 write violation redirect");
    rreg(3'd5, d); chk(d == 2, "R8 status bit", d, 2);
    chk(irq == 1, "R10 irq write", irq, 1);
    xl(32'h0003_0010, 0, 36'h0_0033_3010, 0, 0, "R8 read ok");
    chk(walks == 7, "R8 cached", walks, 7);
    wreg(3'd5, 32'h2);
    wreg(3'd0, 32'h0000_0003);
    xl(32'h0003_0020, 1, 36'h0_000E_E020, 1, 0, "R8 R10 hit fault no abort");
    chk(irq == 0, "R10 irq masked", irq, 0);
    rreg(3'd4, d); chk(d == 32'h0003_0020, "R13 fault va update", d, 32'h0003_0020);
    wreg(3'd5, 32'h2);
    wreg(3'd0, 32'h0000_00FF);
    wreg(3'd2, 32'h0);

    w0 = walks;
    wreg(3'd3, 32'h0000_0FFF);
    xl(32'h1234_5000, 0, 36'h0, 1, 1, "R9 limit");
    rreg(3'd5, d); chk(d == 4, "R9 status bit", d, 4);
    chk(walks == w0, "R9 no fetch", walks, w0);
    wreg(3'd5, 32'h4);
    wreg(3'd3, 32'h000F_FFFF);

    wreg(3'd0, 32'h0000_01FF);
    rreg(3'd5, d); chk(d[8] == 1, "R12 busy", d[8], 1);
    chk(req_ready == 0, "R12 not ready", req_ready, 0);
    for (int k = 0; k < 50 && d[8]; k++) begin @(negedge clk); rreg(3'd0, d); end
    chk(d[8] == 0, "R12 busy ends", d[8], 0);
    w0 = walks;
    xl(32'h0000_5123, 0, 36'h0_00AB_C123, 0, 0, "R12 after clear");
    chk(walks == w0 + 1, "R12 refetch", walks, w0 + 1);

    w0 = walks;
    for (int k = 0; k < 8; k++)
      xl(32'h0020_0000 + 32'(k << 12), 0, 36'h0_0050_0000 + 36'(k << 12), 0, 0, "R6 fill");
    chk(walks == w0 + 8, "R6 eight fills", walks, w0 + 8);
    for (int k = 0; k < 8; k++)
      xl(32'h0020_0000 + 32'(k << 12), 0, 36'h0_0050_0000 + 36'(k << 12), 0, 0, "R6 rehit");
    chk(walks == w0 + 8, "R6 all hit", walks, w0 + 8);
    xl(32'h0020_8000, 0, 36'h0_0050_8000, 0, 0, "R6 ninth");
    xl(32'h0020_1000, 0, 36'h0_0050_1000, 0, 0, "R6 second kept");
    chk(walks == w0 + 9, "R6 second hits", walks, w0 + 9);
    xl(32'h0020_0000, 0, 36'h0_0050_0000, 0, 0, "R6 oldest");
    chk(walks == w0 + 10, "R6 oldest evicted", walks, w0 + 10);

    summary();
  end
endmodule